// File: doc/BRIEF.md
# Power Management Event Aggregator

This block gathers wake and management events from eight sources: a power button status pulse, a lid input with selectable polarity, an active-low general purpose input, an external management request and four serial-bus event lines. Every source owns a sticky status bit and an enable bit. Software reaches them through a small register port with a combinational read path.

A single mode bit sends enabled events either to a system management interrupt or to a control interrupt. Only the power button, lid and general purpose sources may raise the control interrupt. The external request and the serial-bus sources always go to the management interrupt. A resume request output is high whenever any enabled event is pending.

The lid and general purpose inputs each pass through a two-flop synchronizer, and their edges are then detected. The remaining sources are synchronous pulses that set status on the clock edge where they are high.

Top module: `pm_event_agg`

Register map (2-bit address):
- address 0, status: bit 0 power button, bit 1 lid, bit 2 general purpose, bit 3 external request, bits 7:4 serial-bus sources 0..3 (write 1 to clear). Bit 8 is the serial-bus summary and bit 9 is the overall summary; both are read-only.
- address 1, enables: bits 7:0, in the same bit order as status.
- address 2, control: bit 0 mode (1 means control interrupt), bit 1 lid polarity (1 means a rising edge is the event, 0 means a falling edge).
- address 3 reads as zero.

## Requirements
- R1: A source event sets its status bit whether or not its enable bit is set. Power button, external and serial-bus events appear in status on the edge where they are sampled high.
- R2: Writing 1 to a status bit at address 0 clears it. Writing 0 leaves it unchanged.
- R3: When a set and a clear reach the same status bit in the same cycle, the bit stays set.
- R4: With mode 0, any pending event (status AND enable) raises smi_o, and sci_o stays low.
- R5: With mode 1, a pending power button, lid or general purpose event raises sci_o and does not raise smi_o.
- R6: Pending external request or serial-bus events raise smi_o in either mode and never raise sci_o.
- R7: Status bit 8 reads as the OR of bits 7:4 and bit 9 reads as the OR of bits 7:0. Writes to bits 8 and 9 have no effect, and each summary bit drops only once all of its child bits are clear.
- R8: A falling edge on gpi_n sets status bit 2 three clock edges after the change. Holding gpi_n low does not set the bit again after it has been cleared.
- R9: The lid status bit 1 is set three clock edges after an input edge of the direction chosen by control bit 1. An edge in the other direction is ignored.
- R10: wake_o is high exactly when some status bit is set together with its enable bit.
- R11: After reset, all status, enable and control bits are zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrbtn_evt | input | 1 | Power button status pulse |
| lid_in | input | 1 | Debounced lid level, asynchronous |
| gpi_n | input | 1 | Active-low general purpose input, asynchronous |
| ext_req | input | 1 | External management request pulse |
| sbus_evt | input | 4 | Serial-bus event pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| smi_o | output | 1 | Management interrupt, level |
| sci_o | output | 1 | Control interrupt, level |
| wake_o | output | 1 | Resume request, level |

## Verification
On every cycle the assertions check the following:
- the control interrupt is never high without the control mode and a pending event from a source allowed to raise it;
- the control interrupt is low in mode 0;
- the resume request equals the OR of the two interrupts;
- a power button pulse is always captured;
- a write-1 clear of the external bit takes effect when no new request arrives.

Some behaviour can only be shown by the bench's scenarios, because it depends on sequences of stimulus:
- the three-edge latency through the synchronizers;
- the choice of edge direction for the lid;
- no repeated set while the general purpose input is held low;
- the set-over-clear priority;
- summary bits that stay up until the last child bit clears.

// File: rtl/pm_event_agg.sv
module pm_event_agg #(
  parameter int SB_N = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwrbtn_evt,
  input  logic            lid_in,
  input  logic            gpi_n,
  input  logic            ext_req,
  input  logic [SB_N-1:0] sbus_evt,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            smi_o,
  output logic            sci_o,
  output logic            wake_o
);
  localparam int NSRC = 4 + SB_N;
  localparam int NSCI = 3;

  logic [NSRC-1:0] st, en, set_v, clr_v, pend;
  logic            mode, lid_pol;
  logic [1:0]      lid_sy, gpi_sy;
  logic            lid_q, gpi_q;
  logic            lid_hit, gpi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lid_sy <= '0;
      lid_q  <= 1'b0;
      gpi_sy <= '1;
      gpi_q  <= 1'b1;
    end else begin
      lid_sy <= {lid_sy[0], lid_in};
      lid_q  <= lid_sy[1];
      gpi_sy <= {gpi_sy[0], gpi_n};
      gpi_q  <= gpi_sy[1];
    end
  end

  assign lid_hit = lid_pol ? (lid_sy[1] & ~lid_q) : (~lid_sy[1] & lid_q);
  assign gpi_hit = ~gpi_sy[1] & gpi_q;

  assign set_v = {sbus_evt, ext_req, gpi_hit, lid_hit, pwrbtn_evt};
  assign clr_v = (wr_en && addr == 2'd0) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      en      <= '0;
      mode    <= 1'b0;
      lid_pol <= 1'b0;
    end else begin
      st <= (st & ~clr_v) | set_v;
      if (wr_en && addr == 2'd1) en <= wdata[NSRC-1:0];
      if (wr_en && addr == 2'd2) {lid_pol, mode} <= wdata[1:0];
    end
  end

  assign pend   = st & en;
  assign sci_o  = mode & (|pend[NSCI-1:0]);
  assign smi_o  = (|pend[NSRC-1:NSCI]) | (~mode & (|pend[NSCI-1:0]));
  assign wake_o = |pend;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[NSRC+1:0] = {|st, |st[NSRC-1:4], st};
      2'd1: rdata[NSRC-1:0] = en;
      2'd2: rdata[1:0]      = {lid_pol, mode};
      default: rdata = '0;
    endcase
  end
endmodule

module pm_event_agg_chk #(
  parameter int NSRC = 8,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] st,
  input logic [NSRC-1:0] en,
  input logic            mode,
  input logic            pwrbtn_evt,
  input logic            ext_req,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata,
  input logic            smi_o,
  input logic            sci_o,
  input logic            wake_o
);
  a_r6_sci_source: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> (mode && |(st[2:0] & en[2:0])));
  a_r4_mode0_no_sci: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> !sci_o);
  a_r10_wake_vs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == (smi_o | sci_o));
  a_r1_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_evt |=> st[0]);
  a_r2_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[3] && !ext_req) |=> !st[3]);
endmodule

bind pm_event_agg pm_event_agg_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .en(en), .mode(mode),
  .pwrbtn_evt(pwrbtn_evt), .ext_req(ext_req), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o));

// File: tb/test_pm_event_agg.sv
module test_pm_event_agg;
  logic clk = 0, rst_n = 0;
  logic pwrbtn_evt = 0, lid_in = 0, gpi_n = 1, ext_req = 0, wr_en = 0;
  logic [3:0] sbus_evt = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic smi_o, sci_o, wake_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_event_agg i_pm_event_agg (.*);

  // {mode, en[7:0], ev[7:0], st_exp[7:0], smi, sci, wake}
  localparam logic [27:0] VEC [8] = '{
    {1'b0, 8'h01, 8'h01, 8'h01, 3'b101},
    {1'b0, 8'h00, 8'h09, 8'h09, 3'b000},
    {1'b1, 8'h01, 8'h01, 8'h01, 3'b011},
    {1'b1, 8'h08, 8'h08, 8'h08, 3'b101},
    {1'b1, 8'hF0, 8'h20, 8'h20, 3'b101},
    {1'b0, 8'hF0, 8'h80, 8'h80, 3'b101},
    {1'b1, 8'h09, 8'h09, 8'h09, 3'b111},
    {1'b0, 8'hFE, 8'h01, 8'h01, 3'b000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    cyc(1);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [7:0] ev);
    pwrbtn_evt = ev[0]; ext_req = ev[3]; sbus_evt = ev[7:4];
    cyc(1);
    pwrbtn_evt = 0; ext_req = 0; sbus_evt = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    cyc(3);
    rst_n = 1;
    cyc(1);
    rd(0, d); chk("R11 status", d, 0);
    rd(1, d); chk("R11 enable", d, 0);
    rd(2, d); chk("R11 control", d, 0);
    chk("R11 outputs", {smi_o, sci_o, wake_o}, 0);

    for (int i = 0; i < 8; i++) begin
      wr(0, 16'h00FF);
      wr(1, {8'h0, VEC[i][26:19]});
      wr(2, {15'h0, VEC[i][27]});
      pulse(VEC[i][18:11]);
      rd(0, d);
      chk("R1 vector status", d[7:0], VEC[i][10:3]);
      chk("R4/R5/R6/R10 vector outputs", {smi_o, sci_o, wake_o}, VEC[i][2:0]);
    end

    wr(1, 0); wr(2, 0); wr(0, 16'h00FF);
    pulse(8'h09);
    wr(0, 16'h0001);
    rd(0, d); chk("R2 write one clears", d[7:0], 8'h08);
    wr(0, 16'h0000);
    rd(0, d); chk("R2 write zero keeps", d[7:0], 8'h08);

    ext_req = 1; wr(0, 16'h0008); ext_req = 0;
    rd(0, d); chk("R3 set beats clear", d[3], 1'b1);

    wr(0, 16'h00FF);
    pulse(8'h30);
    rd(0, d); chk("R7 summaries set", d[9:8], 2'b11);
    wr(0, 16'h0300);
    rd(0, d); chk("R7 summary write ignored", d[9:0], 10'h330);
    wr(0, 16'h0010);
    rd(0, d); chk("R7 summary held by child", d[9:8], 2'b11);
    wr(0, 16'h0020);
    rd(0, d); chk("R7 summary drops", d[9:8], 2'b00);

    gpi_n = 0; cyc(2);
    rd(0, d); chk("R8 gpi not yet", d[2], 1'b0);
    cyc(1);
    rd(0, d); chk("R8 gpi falling sets", d[2], 1'b1);
    wr(0, 16'h0004); cyc(3);
    rd(0, d); chk("R8 held low no reset", d[2], 1'b0);
    gpi_n = 1; cyc(4);
    rd(0, d); chk("R8 rising ignored", d[2], 1'b0);

    wr(2, 16'h0002);
    lid_in = 1; cyc(3);
    rd(0, d); chk("R9 rising with pol 1", d[1], 1'b1);
    wr(0, 16'h0002);
    lid_in = 0; cyc(4);
    rd(0, d); chk("R9 falling ignored pol 1", d[1], 1'b0);
    wr(2, 16'h0000);
    lid_in = 1; cyc(4);
    rd(0, d); chk("R9 rising ignored pol 0", d[1], 1'b0);
    lid_in = 0; cyc(3);
    rd(0, d); chk("R9 falling with pol 0", d[1], 1'b1);

    wr(1, 16'h0002);
    chk("R10 wake from lid", wake_o, 1'b1);
    wr(1, 16'h0000);
    chk("R10 wake clears with enable", wake_o, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule